// File: doc/BRIEF.md
# Cascadable Segment Line Loader

This block fills one display line of 240 segment bits from an 8-bit parallel data bus. It is one link in a chain of identical drivers that share the same data bus, shift clock and line pulse. Each link sits in standby until its chain-enable input goes low. It then takes one byte on every falling edge of the shift clock. After the twenty-ninth byte it pulls its own chain-enable output low, so the next link can get ready before this one finishes. After the thirtieth byte it stops by itself and ignores the bus until the next line pulse.

A single direction input sets two things. It picks which of the two enable pins is the input and which is the output. It also reverses the whole byte-to-segment placement, including the bit order inside each byte. The shift clock and line pulse are level inputs that are sampled on a faster system clock. Their falling edges are found on that clock, and all state changes on its rising edge.

Top module: `seg_line_loader`

## Requirements
- R1: While loading, each shift-clock falling edge captures all 8 data bits into the line at once, and 30 such edges fill all 240 bits. The captured byte appears on `line_o` one system-clock edge after the shift clock is seen low.
- R2: A low level on the active enable input wakes the block from standby. A shift-clock falling edge seen on the same system-clock edge as the wake, or while the enable input is high, captures nothing. The first byte is taken on the next falling edge.
- R3: The active enable output stays high through the first 28 captured bytes. It goes low on the same system-clock edge that writes the 29th byte.
- R4: Once 30 bytes have been captured, further shift-clock edges change nothing on `line_o`. A held-low enable input does not restart loading until a line-pulse falling edge has occurred.
- R5: With `dir_i`=0, bit b of byte k (k=0..29, b=0..7) lands on `line_o[8k+7-b]`. `line_o[0]` is the first segment.
- R6: With `dir_i`=1, bit b of byte k lands on `line_o[239-(8k+7-b)]`. The first byte therefore fills segments 233..240, with bit 0 on the lowest segment of its group.
- R7: With `dir_i`=0, `ena_i` is the enable input and `enb_o` is the driven output (`enb_oe`=1, `ena_oe`=0). With `dir_i`=1 the roles swap. The non-driving output is held high, and the unused enable input has no effect.
- R8: A line-pulse falling edge drives the enable output high, clears the byte count and returns the block to standby. The captured line is kept.
- R9: Reset leaves the block in standby with `line_o` all zero and both enable outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shclk_i | input | 1 | Shift clock level; a byte is taken on its falling edge |
| lpulse_i | input | 1 | Line pulse level; its falling edge ends the line |
| dir_i | input | 1 | Direction: pin roles and segment order |
| data_i | input | 8 | Parallel display data |
| ena_i | input | 1 | Enable pin A, input side (active low) |
| enb_i | input | 1 | Enable pin B, input side (active low) |
| ena_o | output | 1 | Enable pin A, output side (active low) |
| enb_o | output | 1 | Enable pin B, output side (active low) |
| ena_oe | output | 1 | Pin A acts as output |
| enb_oe | output | 1 | Pin B acts as output |
| line_o | output | 240 | Captured line, index 0 is the first segment |

## Verification
If the byte counter is off by one, the enable output falls one shift-clock period early or late. That is visible at the port on the 28th or 29th byte, and every later byte then lands in a shifted group of `line_o`. If the state is wrong, a stray byte gets written: the bus is still active after the 30th edge, during standby, or on the wake edge. That shows as a changed `line_o` group one system clock after the offending edge. If the placement logic is wrong, bits show up swapped or in the wrong group, which a full-line compare catches as soon as the line is complete.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ld_state_t;
endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/seg_byte_seq.sv
module seg_byte_seq
  import seg_loader_pkg::*;
#(
  parameter int BYTES = 30,
  parameter int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_in_n,
  input  logic             sh_fall,
  input  logic             lp_fall,
  output logic             wr_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             en_out_n_o
);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(BYTES - 1);
  localparam logic [CNT_W-1:0] EARLY_IDX = CNT_W'(BYTES - 2);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(BYTES);

  ld_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             eo_q;

  assign wr_o       = (state_q == ST_RUN) && sh_fall && !lp_fall;
  assign idx_o      = cnt_q;
  assign en_out_n_o = eo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      eo_q    <= 1'b1;
    end else if (lp_fall) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      eo_q    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (!en_in_n) state_q <= ST_RUN;
        ST_RUN: if (sh_fall) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == EARLY_IDX) eo_q <= 1'b0;
          if (cnt_q == LAST_IDX)  state_q <= ST_DONE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  AST_IDLE_EO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> eo_q);                                  // R8
  AST_EO_FALL_AT_29: assert property (@(posedge clk) disable iff (rst)
    $fell(eo_q) |-> (cnt_q == LAST_IDX));                            // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);                                              // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !lp_fall) |=> (state_q == ST_DONE) && $stable(cnt_q)); // R4
endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int BUS_W = 8,
  parameter int BYTES = 30,
  parameter int CNT_W = $clog2(BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  logic [CNT_W-1:0]       idx_i,
  input  logic                   dir_i,
  input  logic [BUS_W-1:0]       data_i,
  output logic [BUS_W*BYTES-1:0] line_o
);
  localparam logic [CNT_W-1:0] TOP_SLOT = CNT_W'(BYTES - 1);

  logic [BUS_W-1:0] slot_q [BYTES];
  logic [CNT_W-1:0] sel;
  logic [BUS_W-1:0] rev_data;
  logic [BUS_W-1:0] word;

  always_comb begin
    for (int b = 0; b < BUS_W; b++) rev_data[b] = data_i[BUS_W-1-b];
  end

  assign sel  = dir_i ? (TOP_SLOT - idx_i) : idx_i;
  assign word = dir_i ? data_i : rev_data;

  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                              slot_q[g] <= '0;
      else if (wr_i && sel == CNT_W'(g))    slot_q[g] <= word;
    end
    assign line_o[g*BUS_W +: BUS_W] = slot_q[g];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> (idx_i <= TOP_SLOT));                                   // R1
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(line_o));                                      // R4
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
  parameter int BUS_W = 8,
  parameter int SEGS  = 240
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shclk_i,
  input  logic            lpulse_i,
  input  logic            dir_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic            ena_i,
  input  logic            enb_i,
  output logic            ena_o,
  output logic            enb_o,
  output logic            ena_oe,
  output logic            enb_oe,
  output logic [SEGS-1:0] line_o
);
  localparam int BYTES = SEGS / BUS_W;
  localparam int CNT_W = $clog2(BYTES + 1);

  logic             sh_fall;
  logic             lp_fall;
  logic             wr;
  logic [CNT_W-1:0] idx;
  logic             en_in_n;
  logic             en_out_n;

  seg_fall_detect i_sh_edge (
    .clk(clk), .rst(rst), .level_i(shclk_i), .fall_o(sh_fall));
  seg_fall_detect i_lp_edge (
    .clk(clk), .rst(rst), .level_i(lpulse_i), .fall_o(lp_fall));

  assign en_in_n = dir_i ? enb_i : ena_i;

  seg_byte_seq #(.BYTES(BYTES), .CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst(rst), .en_in_n(en_in_n), .sh_fall(sh_fall),
    .lp_fall(lp_fall), .wr_o(wr), .idx_o(idx), .en_out_n_o(en_out_n));

  seg_line_store #(.BUS_W(BUS_W), .BYTES(BYTES), .CNT_W(CNT_W)) i_store (
    .clk(clk), .rst(rst), .wr_i(wr), .idx_i(idx), .dir_i(dir_i),
    .data_i(data_i), .line_o(line_o));

  assign ena_oe = dir_i;
  assign enb_oe = ~dir_i;
  assign ena_o  = dir_i ? en_out_n : 1'b1;
  assign enb_o  = dir_i ? 1'b1 : en_out_n;

  AST_LP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    lp_fall |=> (ena_o && enb_o));                                   // R8
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot({ena_oe, enb_oe}) && (ena_oe ? enb_o : ena_o));          // R7
endmodule

// File: tb/test_seg_line_loader.sv
module test_seg_line_loader;
  localparam int SEGS = 240;

  typedef struct {
    logic [SEGS-1:0] line;
    string           req;
  } sb_item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            shclk_i = 1'b0;
  logic            lpulse_i = 1'b0;
  logic            dir_i = 1'b0;
  logic [7:0]      data_i = '0;
  logic            ena_i = 1'b1;
  logic            enb_i = 1'b1;
  logic            ena_o, enb_o, ena_oe, enb_oe;
  logic [SEGS-1:0] line_o;

  int checks = 0;
  int errors = 0;
  sb_item_t sb_q[$];
  logic [SEGS-1:0] exp_line = '0;

  always #5 clk = ~clk;

  seg_line_loader i_seg_line_loader (
    .clk(clk), .rst(rst), .shclk_i(shclk_i), .lpulse_i(lpulse_i),
    .dir_i(dir_i), .data_i(data_i), .ena_i(ena_i), .enb_i(enb_i),
    .ena_o(ena_o), .enb_o(enb_o), .ena_oe(ena_oe), .enb_oe(enb_oe),
    .line_o(line_o));

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic push_exp(string req);
    sb_item_t it;
    it.line = exp_line;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  // monitor: pops expected lines and compares against the port
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (line_o !== it.line) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, line_o, it.line);
        end
      end
    end
  end

  task automatic shift_byte(logic [7:0] d);
    @(negedge clk); data_i = d; shclk_i = 1'b1;
    @(negedge clk);
    @(negedge clk); shclk_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic line_pulse();
    @(negedge clk); lpulse_i = 1'b1;
    @(negedge clk);
    @(negedge clk); lpulse_i = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic out_pin();
    return dir_i ? ena_o : enb_o;
  endfunction

  task automatic load_line(int seed);
    for (int k = 0; k < 30; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + seed * 11) ^ 8'h5A);
      shift_byte(v);
      for (int b = 0; b < 8; b++) begin
        int idx;
        idx = 8 * k + 7 - b;
        if (dir_i) idx = 239 - idx;
        exp_line[idx] = v[b];
      end
      if (k == 27) check_bit("R3 before 29th", out_pin(), 1'b1);
      if (k == 28) check_bit("R3 after 29th", out_pin(), 1'b0);
    end
    push_exp(dir_i ? "R6 R1 full line" : "R5 R1 full line");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check_bit("R9 ena_o", ena_o, 1'b1);
    check_bit("R9 enb_o", enb_o, 1'b1);
    push_exp("R9 line cleared");
    // R7 pin roles with dir=0
    check_bit("R7 enb_oe", enb_oe, 1'b1);
    check_bit("R7 ena_oe", ena_oe, 1'b0);
    // R2: no capture while enable input high
    shift_byte(8'hA5);
    push_exp("R2 standby ignores bus");
    // R2: wake on same edge as a shift-clock fall, that fall is ignored
    @(negedge clk); data_i = 8'hFF; shclk_i = 1'b1;
    @(negedge clk);
    @(negedge clk); shclk_i = 1'b0; ena_i = 1'b0;
    @(negedge clk);
    push_exp("R2 wake edge ignored");
    load_line(1);
    // R4 extra byte after full line
    shift_byte(8'h3C);
    push_exp("R4 stop after 30");
    check_bit("R4 eo held low", enb_o, 1'b0);
    repeat (4) @(negedge clk);
    shift_byte(8'hC3);
    push_exp("R4 held enable no restart");
    // R8 line pulse
    line_pulse();
    check_bit("R8 eo released", enb_o, 1'b1);
    push_exp("R8 line kept");
    // second line, enable still low restarts after pulse
    load_line(2);
    line_pulse();
    // R7 swap roles with dir=1
    dir_i = 1'b1; ena_i = 1'b0; enb_i = 1'b1;
    @(negedge clk);
    check_bit("R7 ena_oe dir1", ena_oe, 1'b1);
    check_bit("R7 enb_oe dir1", enb_oe, 1'b0);
    check_bit("R7 enb_o idle high", enb_o, 1'b1);
    shift_byte(8'h81);
    push_exp("R7 unused input ignored");
    enb_i = 1'b0;
    @(negedge clk);
    load_line(3);
    check_bit("R7 enb_o stays high", enb_o, 1'b1);
    line_pulse();
    check_bit("R8 ena_o released", ena_o, 1'b1);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule